// File: doc/BRIEF.md
# I2C Interrupt Flag and Vector Controller

This block sits beside an I2C controller core and turns seven single-cycle event strobes into sticky status flags, one masked CPU interrupt request and a priority-encoded vector code. The events are arbitration lost, no-acknowledge, registers ready for access, receive ready, transmit ready, stop detected and addressed as slave. The interrupt line is dedicated to this block and is not shared with any other source.

Software reaches three small registers: a status register, a mask register and a vector register. Status bits are cleared by writing ones. The vector register is read-only. Reading it clears only the highest-priority enabled flag. The interrupt request is held low for one clock after that read, then comes back if other enabled flags remain, so an edge-triggered CPU input sees a fresh edge. Receive-ready and transmit-ready events also produce single-cycle DMA request strobes, so a DMA engine can move data without CPU help.

Top module: `i2c_irq_vector`

## Requirements
- R1: A synchronous active-high reset clears all flags, clears the mask to zero, and drives the interrupt request and both DMA strobes low.
- R2: Event input bit k sets status flag k on the next clock, and the flag stays set until cleared. Bit order is 0 arbitration lost, 1 no-acknowledge, 2 registers ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. Register address 0 is status, address 1 is mask (read/write, bits 6:0), and address 2 is the vector. Read data is combinational on the address.
- R3: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. An event on the same flag in the same cycle wins, so the flag stays set.
- R4: The interrupt request is registered. It is high exactly when some flag with its mask bit at 1 is set, and it follows flag changes on the same clock edge.
- R5: The vector register reads k+1, where k is the lowest-numbered set flag whose mask bit is 1. Bit 0 has the highest priority. The register reads 0 when no enabled flag is set. Masked flags do not affect the code.
- R6: A read strobe at address 2 clears only the flag the vector reports. All other flags, masked or not, stay set. A read that returns 0 changes nothing.
- R7: The interrupt request is low in the cycle after a vector read. In the following cycle it is high again if any enabled flag is still set.
- R8: The receive DMA strobe and the transmit DMA strobe each go high for exactly one cycle after each rising edge of the receive-ready event (bit 3) and the transmit-ready event (bit 4), respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_i | input | 7 | Event strobes from the I2C core, in flag bit order |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect only on the vector) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Masked interrupt request |
| dma_rx_o | output | 1 | Receive DMA request strobe |
| dma_tx_o | output | 1 | Transmit DMA request strobe |

## Verification
The hardest cases are vector reads with several flags pending, where some of them are masked and sit at higher priority than the reported one. Random traffic rarely produces these. The stimulus loads every one of the 128 flag patterns under each of the 128 masks in one cycle, through the event inputs together with a mask write. It then reads the vector and checks the cleared pattern, the dropped request and the re-asserted request against a priority encode computed in the bench.

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector #(
  parameter int NEV = 7,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NEV-1:0] ev_i,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o,
  output logic          dma_rx_o,
  output logic          dma_tx_o
);
  localparam int VW = $clog2(NEV + 1);
  localparam int RXB = 3;
  localparam int TXB = 4;
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_VEC  = 2'd2;

  logic [NEV-1:0] flags, mask, pend, pick, flags_d, mask_d, ev_q;
  logic [VW-1:0]  vec;
  logic           irq_q, rx_q, tx_q;

  wire vec_rd = reg_rd && reg_addr == A_VEC;
  wire st_wr  = reg_wr && reg_addr == A_STAT;
  wire mk_wr  = reg_wr && reg_addr == A_MASK;

  assign pend = flags & mask;

  always_comb begin
    vec  = '0;
    pick = '0;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vec     = VW'(i + 1);
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  wire [NEV-1:0] w1c = st_wr ? reg_wdata[NEV-1:0] : '0;
  wire [NEV-1:0] rdc = vec_rd ? pick : '0;

  assign flags_d = (flags & ~w1c & ~rdc) | ev_i;
  assign mask_d  = mk_wr ? reg_wdata[NEV-1:0] : mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      mask  <= '0;
      irq_q <= 1'b0;
      ev_q  <= '0;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      flags <= flags_d;
      mask  <= mask_d;
      irq_q <= !vec_rd && |(flags_d & mask_d);
      ev_q  <= ev_i;
      rx_q  <= ev_i[RXB] && !ev_q[RXB];
      tx_q  <= ev_i[TXB] && !ev_q[TXB];
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = DW'(flags);
      A_MASK:  reg_rdata = DW'(mask);
      A_VEC:   reg_rdata = DW'(vec);
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o    = irq_q;
  assign dma_rx_o = rx_q;
  assign dma_tx_o = tx_q;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (flags == '0 && mask == '0 && !irq_o && !dma_rx_o && !dma_tx_o));

  p_event_sticks_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_i != '0) |=> ((flags & $past(ev_i)) == $past(ev_i)));

  p_irq_needs_pending_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend != '0));

  p_read_clears_one_r6: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && vec != '0 && ev_i == '0 && !st_wr)
      |=> ($countones(flags) + 1 == $past($countones(flags))));

  p_gap_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    vec_rd |=> !irq_o);

  p_rx_single_r8: assert property (@(posedge clk) disable iff (rst)
    dma_rx_o |=> !dma_rx_o);

  p_tx_single_r8: assert property (@(posedge clk) disable iff (rst)
    dma_tx_o |=> !dma_tx_o);
endmodule

// File: tb/i2c_irq_vector_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_vector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] ev_i = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o, dma_rx_o, dma_tx_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  i2c_irq_vector dut_i (
    .clk(clk), .rst(rst), .ev_i(ev_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .dma_rx_o(dma_rx_o), .dma_tx_o(dma_tx_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [1:0] a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 dma", int'({dma_rx_o, dma_tx_o}), 0);
    rd_reg(2'd0, v); chk("R1 status", v, 0);
    rd_reg(2'd1, v); chk("R1 mask", v, 0);
    rd_reg(2'd2, v); chk("R1 vector", v, 0);

    // R8 single pulse and held event
    ev_i = 7'h08; step(); ev_i = '0;
    chk("R8 rx pulse", int'(dma_rx_o), 1);
    chk("R8 tx quiet", int'(dma_tx_o), 0);
    step();
    chk("R8 rx ends", int'(dma_rx_o), 0);
    ev_i = 7'h10; step();
    chk("R8 tx pulse", int'(dma_tx_o), 1);
    step();
    chk("R8 tx once while held", int'(dma_tx_o), 0);
    step(); ev_i = '0; step();
    chk("R8 tx still once", int'(dma_tx_o), 0);

    // R3 write-one-to-clear and collision
    reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 8'h18; ev_i = 7'h10; step();
    reg_wr = 1'b0; ev_i = '0;
    rd_reg(2'd0, v); chk("R3 collision keeps flag", v, 8'h10);
    reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 8'h00; step(); reg_wr = 1'b0;
    rd_reg(2'd0, v); chk("R3 zero write no effect", v, 8'h10);
    reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 8'h7F; step(); reg_wr = 1'b0;
    rd_reg(2'd0, v); chk("R3 clear", v, 0);

    // R6 read of empty vector with masked flag pending
    ev_i = 7'h01; step(); ev_i = '0;
    reg_addr = 2'd2; reg_rd = 1'b1; step(); reg_rd = 1'b0;
    rd_reg(2'd0, v); chk("R6 empty read no clear", v, 1);
    reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 8'h7F; step(); reg_wr = 1'b0;

    // R2 R4 R5 R6 R7 sweep over all flag patterns and masks
    for (int m = 0; m < 128; m++) begin
      for (int f = 0; f < 128; f++) begin
        int en, code, rem;
        en = f & m;
        code = 0;
        for (int i = 6; i >= 0; i--) if (en[i]) code = i + 1;
        rem = (code != 0) ? (f & ~(1 << (code - 1))) : f;
        ev_i = 7'(f); reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 8'(m);
        step();
        ev_i = '0; reg_wr = 1'b0;
        chk("R4 irq", int'(irq_o), int'(en != 0));
        rd_reg(2'd0, v); chk("R2 status", v, f);
        rd_reg(2'd1, v); chk("R2 mask", v, m);
        rd_reg(2'd2, v); chk("R5 vector", v, code);
        reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
        chk("R7 gap", int'(irq_o), 0);
        rd_reg(2'd0, v); chk("R6 after read", v, rem);
        step();
        chk("R7 reassert", int'(irq_o), int'((rem & m) != 0));
        reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 8'h7F;
        step();
        reg_wr = 1'b0;
        if (f == 127) begin
          rd_reg(2'd0, v); chk("R3 clear all", v, 0);
        end
      end
    end

    // R1 reset mid-operation
    ev_i = 7'h7F; reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 8'h7F; step();
    ev_i = '0; reg_wr = 1'b0; rst = 1'b1; step(); rst = 1'b0;
    chk("R1 irq after reset", int'(irq_o), 0);
    rd_reg(2'd0, v); chk("R1 status after reset", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule